// File: doc/BRIEF.md
# Flow-Controlled SPI Port

This block is an SPI serial port with one added handshake line that carries flow control. As a slave it takes 8-bit frames from an external host and stores them in a 16-entry receive queue. The system side drains that queue through a simple read port. An active-low ready output tells the host when it may clock in data. The port keeps this line inactive during reset, until the system reports that initialization has finished, and whenever the queue is three quarters full or more.

As a master the same handshake line changes direction and becomes an input. The port shifts bytes out from a transmit source, and it starts a byte only once it has seen the remote side pull the line low. If the remote side releases the line partway through a byte, the port finishes that byte and then waits with the clock idle and chip select released.

All SPI inputs are oversampled in the system clock domain. The serial clock must run at no more than one quarter of the system clock.

Top module: `spi_rdy_port`

## Requirements
- R1: While reset is held and right after it, rdy_n_o is 1, rd_valid is 0, overflow is 0, spi_cs_n_o is 1 and spi_sclk_o is 0.
- R2: In slave mode rdy_n_o stays 1 while init_done is 0. Once init_done is 1 and the queue holds fewer than 12 entries, it goes to 0 (allowed).
- R3: In slave mode rdy_n_o is 1 whenever the queue holds 12 or more of its 16 entries, and it returns to 0 once the level drops below 12. A host that sends only while rdy_n_o is 0 never causes an overflow.
- R4: In slave mode, while spi_cs_n_i is 0, each 8 rising edges of spi_sclk_i assemble one byte from spi_mosi_i, most significant bit first. Bytes leave the read port in arrival order.
- R5: Raising spi_cs_n_i before the 8th bit discards the partial byte, and the next frame starts at bit 7.
- R6: A byte that completes while the queue holds 16 entries (with no pop in that cycle) is dropped, and overflow becomes 1. Overflow stays 1 until an ovf_clr pulse.
- R7: rd_valid is 1 exactly when the queue is non-empty, and rd_data shows the oldest entry. rd_en pops one entry. rd_en while empty has no effect.
- R8: In master mode a byte starts (tx_accept pulses and spi_cs_n_o falls) only while the synchronized rdy_n_i is 0. While rdy_n_i is 1 the port waits with spi_cs_n_o at 1 and spi_sclk_o at 0.
- R9: In master mode each byte is shifted out on spi_mosi_o MSB first, in SPI mode 0, with an SCLK period of 4 system clocks. If rdy_n_i rises during a byte, that byte still completes and the next one waits.
- R10: rdy_oe is 1 in slave mode and 0 in master mode. In master mode rdy_n_o is 1 and activity on the slave SPI inputs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 selects master, 0 selects slave |
| init_done | input | 1 | System initialization finished |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| spi_sclk_i | input | 1 | Slave serial clock from the host |
| spi_cs_n_i | input | 1 | Slave chip select, active low |
| spi_mosi_i | input | 1 | Slave serial data in |
| spi_sclk_o | output | 1 | Master serial clock |
| spi_cs_n_o | output | 1 | Master chip select, active low |
| spi_mosi_o | output | 1 | Master serial data out |
| rdy_n_i | input | 1 | Ready line sampled in master mode, active low |
| rdy_n_o | output | 1 | Ready line driven in slave mode, active low |
| rdy_oe | output | 1 | Output enable for the ready line |
| tx_valid | input | 1 | Master transmit byte present |
| tx_data | input | 8 | Master transmit byte |
| tx_accept | output | 1 | Transmit byte taken this cycle |
| rd_en | input | 1 | Pop request on the read port |
| rd_valid | output | 1 | Queue non-empty |
| rd_data | output | 8 | Oldest queued byte |
| overflow | output | 1 | Sticky drop flag |

## Verification
The two functions that can land in the same system clock cycle are a byte completing from the serial side and a pop from the read side. The random phase provokes this coincidence. A host that obeys ready streams random bytes while a slow reader pops at random moments, so pushes and pops meet at many queue levels, including around the threshold. The bench judges the result by comparing every popped byte against its own ordered list of sent bytes. It also requires that overflow never rises, because a host that honours rdy_n_o must never fill the queue.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  typedef enum logic [1:0] {M_IDLE, M_LOW, M_HIGH} mst_state_t;

  // Fill level at which the host is held off: three quarters of depth.
  function automatic int fill_limit(input int depth);
    return (depth * 3) / 4;
  endfunction

  // Slave may accept new host data.
  function automatic logic host_may_send(input logic init_ok, input logic is_master,
                                         input int level, input int limit);
    return init_ok && !is_master && (level < limit);
  endfunction
endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rdy_slave_rx.sv
module spi_rdy_slave_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          byte_done,
  output logic [DW-1:0] byte_out
);
  localparam int CW = $clog2(DW);

  logic          sclk_d;
  logic          sclk_rise;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;

  assign sclk_rise = sclk && !sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_out  <= '0;
    end else begin
      sclk_d    <= sclk;
      byte_done <= 1'b0;
      if (!en || cs_n) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[DW-2:0], mosi};
        if (bit_cnt == CW'(DW - 1)) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          byte_out  <= {shreg[DW-2:0], mosi};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rdy_fifo.sv
module spi_rdy_fifo #(
  parameter int DW = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [DW-1:0]              wdata,
  input  logic                       rd,
  input  logic                       ovf_clr,
  output logic                       rvalid,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          pop, full, push;

  assign full   = (level == LW'(DEPTH));
  assign rvalid = (level != '0);
  assign pop    = rd && rvalid;
  assign push   = wr && (!full || pop);
  assign rdata  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr && !push)  ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_rdy_master_tx.sv
module spi_rdy_master_tx #(
  parameter int DW = 8,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rdy_n,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_accept,
  output logic          sclk_o,
  output logic          cs_n_o,
  output logic          mosi_o
);
  import spi_rdy_pkg::*;
  localparam int CW = $clog2(DW);
  localparam int VW = $clog2(HALF + 1);

  mst_state_t    state;
  logic [VW-1:0] div;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic          half_done;

  assign tx_accept = (state == M_IDLE) && en && tx_valid && !rdy_n;
  assign half_done = (div == VW'(HALF - 1));
  assign mosi_o    = shreg[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= M_IDLE;
      div     <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      sclk_o  <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      case (state)
        M_IDLE: begin
          if (tx_accept) begin
            shreg   <= tx_data;
            bit_cnt <= '0;
            div     <= '0;
            cs_n_o  <= 1'b0;
            state   <= M_LOW;
          end
        end
        M_LOW: begin
          div <= half_done ? '0 : div + 1'b1;
          if (half_done) begin
            sclk_o <= 1'b1;
            state  <= M_HIGH;
          end
        end
        M_HIGH: begin
          div <= half_done ? '0 : div + 1'b1;
          if (half_done) begin
            sclk_o <= 1'b0;
            if (bit_cnt == CW'(DW - 1)) begin
              cs_n_o <= 1'b1;
              state  <= M_IDLE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[DW-2:0], 1'b0};
              state   <= M_LOW;
            end
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_rdy_port.sv
module spi_rdy_port #(
  parameter int DW = 8,
  parameter int DEPTH = 16,
  parameter int HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          init_done,
  input  logic          ovf_clr,
  input  logic          spi_sclk_i,
  input  logic          spi_cs_n_i,
  input  logic          spi_mosi_i,
  output logic          spi_sclk_o,
  output logic          spi_cs_n_o,
  output logic          spi_mosi_o,
  input  logic          rdy_n_i,
  output logic          rdy_n_o,
  output logic          rdy_oe,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_accept,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          overflow
);
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int THR = spi_rdy_pkg::fill_limit(DEPTH);

  logic [LW-1:0] fifo_level;
  logic          rx_done;
  logic [DW-1:0] rx_byte;
  logic          s_sclk, s_cs_n, s_mosi;
  logic          rdy_sync_n;

  spi_rdy_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync_slave (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk_i, spi_cs_n_i, spi_mosi_i}),
    .q({s_sclk, s_cs_n, s_mosi})
  );

  spi_rdy_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_sync_rdy (
    .clk(clk), .rst_n(rst_n), .d(rdy_n_i), .q(rdy_sync_n)
  );

  spi_rdy_slave_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!master_mode),
    .sclk(s_sclk), .cs_n(s_cs_n), .mosi(s_mosi),
    .byte_done(rx_done), .byte_out(rx_byte)
  );

  spi_rdy_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(rx_done), .wdata(rx_byte),
    .rd(rd_en), .ovf_clr(ovf_clr), .rvalid(rd_valid), .rdata(rd_data),
    .level(fifo_level), .ovf(overflow)
  );

  spi_rdy_master_tx #(.DW(DW), .HALF(HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(master_mode), .rdy_n(rdy_sync_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_accept(tx_accept),
    .sclk_o(spi_sclk_o), .cs_n_o(spi_cs_n_o), .mosi_o(spi_mosi_o)
  );

  assign rdy_oe = !master_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_n_o <= 1'b1;
    else        rdy_n_o <= !spi_rdy_pkg::host_may_send(init_done, master_mode,
                                                       int'(fifo_level), THR);
  end
endmodule

// File: rtl/spi_rdy_port_chk.sv
module spi_rdy_port_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       master_mode,
  input logic                       init_done,
  input logic                       ovf_clr,
  input logic                       rdy_n_o,
  input logic                       overflow,
  input logic                       spi_cs_n_o,
  input logic                       spi_sclk_o,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       rdy_sync_n
);
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int THR = spi_rdy_pkg::fill_limit(DEPTH);

  AST_RDY_HOLD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> rdy_n_o); // R2
  AST_RDY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= LW'(THR)) |=> rdy_n_o); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow); // R6
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> !$past(rdy_sync_n)); // R8
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sclk_o); // R9
  AST_RDY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |=> rdy_n_o); // R10
endmodule

bind spi_rdy_port spi_rdy_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .init_done(init_done),
  .ovf_clr(ovf_clr), .rdy_n_o(rdy_n_o), .overflow(overflow),
  .spi_cs_n_o(spi_cs_n_o), .spi_sclk_o(spi_sclk_o),
  .level(fifo_level), .rdy_sync_n(rdy_sync_n)
);

// File: tb/spi_rdy_port_bench.sv
`timescale 1ns/1ps
module spi_rdy_port_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b0, init_done = 1'b0, ovf_clr = 1'b0;
  logic spi_sclk_i = 1'b0, spi_cs_n_i = 1'b1, spi_mosi_i = 1'b0;
  logic spi_sclk_o, spi_cs_n_o, spi_mosi_o;
  logic rdy_n_i = 1'b1;
  logic rdy_n_o, rdy_oe;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_accept;
  logic rd_en = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic overflow;

  int n_chk = 0, n_fail = 0, cycles = 0, n_accept = 0;
  logic [7:0] mrx [0:63];
  int mrx_n = 0, mcnt = 0;
  logic [7:0] mbits = '0;
  realtime last_rise = 0, sclk_period = 0;
  logic [7:0] exp_q [0:63];

  always #5 clk = ~clk;

  spi_rdy_port u_spi_rdy_port (.*);

  // Watchdog and accept counter
  always @(posedge clk) begin
    cycles++;
    if (tx_accept) n_accept++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected<150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Remote receiver for master mode: mode 0, MSB first
  always @(posedge spi_sclk_o or posedge spi_cs_n_o) begin
    if (spi_cs_n_o) mcnt = 0;
    else begin
      if (last_rise != 0) sclk_period = $realtime - last_rise;
      last_rise = $realtime;
      mbits = {mbits[6:0], spi_mosi_o};
      mcnt++;
      if (mcnt == 8) begin mrx[mrx_n] = mbits; mrx_n++; mcnt = 0; last_rise = 0; end
    end
  end

  function automatic logic exp_rdy_n(logic init, logic mst, int lvl);
    return !init || mst || (lvl * 4 >= DEPTH * 3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    spi_cs_n_i = 1'b0;
    wait_clk(4);
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi_i = b[i];
      wait_clk(4);
      spi_sclk_i = 1'b1;
      wait_clk(4);
      spi_sclk_i = 1'b0;
    end
    wait_clk(4);
    spi_cs_n_i = 1'b1;
    wait_clk(8);
  endtask

  task automatic pop_chk(string req, logic [7:0] exp);
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, {24'd0, rd_data}, {24'd0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic master_send(logic [7:0] b);
    tx_data = b; tx_valid = 1'b1;
    while (!tx_accept) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_clk(3);
    // R1: reset values
    chk("R1 rdy_n_o", {31'd0, rdy_n_o}, 32'd1);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 overflow", {31'd0, overflow}, 32'd0);
    chk("R1 cs_n_o", {31'd0, spi_cs_n_o}, 32'd1);
    chk("R1 sclk_o", {31'd0, spi_sclk_o}, 32'd0);
    rst_n = 1'b1;
    wait_clk(20);
    // R2: held off until init done
    chk("R2 no init", {31'd0, rdy_n_o}, {31'd0, exp_rdy_n(1'b0, 1'b0, 0)});
    init_done = 1'b1;
    wait_clk(3);
    chk("R2 init", {31'd0, rdy_n_o}, {31'd0, exp_rdy_n(1'b1, 1'b0, 0)});
    chk("R10 oe slave", {31'd0, rdy_oe}, 32'd1);

    // R4: basic receive, MSB first, in order
    send_bits(8'hA5, 8);
    send_bits(8'h3C, 8);
    pop_chk("R4 first", 8'hA5);
    pop_chk("R4 second", 8'h3C);
    chk("R7 empty", {31'd0, rd_valid}, 32'd0);

    // R7: pop on empty has no effect
    rd_en = 1'b1; wait_clk(3); rd_en = 1'b0;
    chk("R7 still empty", {31'd0, rd_valid}, 32'd0);
    send_bits(8'h5A, 8);
    pop_chk("R7 after empty pop", 8'h5A);

    // R5: aborted partial frame
    send_bits(8'hFF, 3);
    chk("R5 partial dropped", {31'd0, rd_valid}, 32'd0);
    send_bits(8'h81, 8);
    pop_chk("R5 realigned", 8'h81);
    chk("R5 one byte only", {31'd0, rd_valid}, 32'd0);

    // R3: threshold at 12 of 16
    for (int i = 0; i < 11; i++) send_bits(8'h10 + 8'(i), 8);
    chk("R3 level 11", {31'd0, rdy_n_o}, {31'd0, exp_rdy_n(1'b1, 1'b0, 11)});
    send_bits(8'h1B, 8);
    chk("R3 level 12", {31'd0, rdy_n_o}, {31'd0, exp_rdy_n(1'b1, 1'b0, 12)});
    pop_chk("R3 pop", 8'h10);
    wait_clk(2);
    chk("R3 back to 11", {31'd0, rdy_n_o}, {31'd0, exp_rdy_n(1'b1, 1'b0, 11)});

    // R6: overflow
    for (int k = 0; k < 5; k++) send_bits(8'h20 + 8'(k), 8);
    chk("R6 full no ovf", {31'd0, overflow}, 32'd0);
    send_bits(8'hEE, 8);
    chk("R6 ovf set", {31'd0, overflow}, 32'd1);
    for (int i = 0; i < 11; i++) pop_chk("R6 kept", 8'h11 + 8'(i));
    for (int k = 0; k < 5; k++) pop_chk("R6 kept tail", 8'h20 + 8'(k));
    chk("R6 dropped", {31'd0, rd_valid}, 32'd0);
    chk("R6 sticky", {31'd0, overflow}, 32'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R6 cleared", {31'd0, overflow}, 32'd0);

    // R3/R4 random: host obeys ready, slow reader pops at random
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          while (rdy_n_o) @(negedge clk);
          exp_q[i] = 8'($urandom);
          send_bits(exp_q[i], 8);
        end
      end
      begin
        int got = 0;
        while (got < 40) begin
          @(negedge clk);
          rd_en = 1'b0;
          if (rd_valid && ($urandom % 100 == 0)) begin
            chk("R4 random order", {24'd0, rd_data}, {24'd0, exp_q[got]});
            got++;
            rd_en = 1'b1;
          end
        end
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
    chk("R3 no ovf under backpressure", {31'd0, overflow}, 32'd0);

    // R10: master mode direction and slave pins ignored
    master_mode = 1'b1;
    wait_clk(3);
    chk("R10 oe master", {31'd0, rdy_oe}, 32'd0);
    chk("R10 rdy_n_o master", {31'd0, rdy_n_o}, 32'd1);
    send_bits(8'h77, 8);
    chk("R10 slave ignored", {31'd0, rd_valid}, 32'd0);

    // R8: stall while remote not ready
    rdy_n_i = 1'b1;
    tx_data = 8'hC3; tx_valid = 1'b1;
    wait_clk(100);
    chk("R8 stall cs", {31'd0, spi_cs_n_o}, 32'd1);
    chk("R8 stall sclk", {31'd0, spi_sclk_o}, 32'd0);
    chk("R8 no accept", n_accept, 32'd0);
    rdy_n_i = 1'b0;
    master_send(8'hC3);
    while (mrx_n < 1) @(negedge clk);
    chk("R9 byte", {24'd0, mrx[0]}, 32'hC3);
    chk("R9 sclk period", int'(sclk_period), 32'd40);

    // R9: ready released mid-byte
    master_send(8'h96);
    wait_clk(3);
    rdy_n_i = 1'b1;
    tx_data = 8'h69; tx_valid = 1'b1;
    wait_clk(150);
    chk("R9 mid-byte completes", mrx_n, 32'd2);
    chk("R9 mid-byte data", {24'd0, mrx[1]}, 32'h96);
    chk("R8 stalled after", {31'd0, spi_cs_n_o}, 32'd1);
    chk("R8 accepts", n_accept, 32'd2);
    rdy_n_i = 1'b0;
    master_send(8'h69);
    while (mrx_n < 3) @(negedge clk);
    chk("R9 resumed", {24'd0, mrx[2]}, 32'h69);

    // R9 random master bytes
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      master_send(b);
      while (mrx_n < 4 + i) @(negedge clk);
      chk("R9 random", {24'd0, mrx[3 + i]}, {24'd0, b});
    end

    wait_clk(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule